// File: doc/BRIEF.md
# Instruction Control Decoder for a Single-Cycle Datapath

This block turns the opcode and function fields of a 32-bit instruction into the control levels that steer a single-cycle datapath: destination select, register write, immediate extension mode, second-operand select, data-memory read and write, write-back source, three separate next-PC flags (branch-if-equal, branch-if-not-equal, jump) and a 4-bit ALU operation code. It is purely combinational. The outputs settle within the same cycle as the instruction bits.

Two parts make up the block. A main decoder looks only at the opcode. An ALU-control decoder looks at the opcode and, for register-register instructions, at the function field. The supported set is add, sub, and, or, slt, addi, andi, ori, lw, sw, beq, bne and j.

Any opcode outside that set, and any function code outside the five supported ones under opcode 000000, drives every output to 0. Outputs whose value does not matter for an instruction are also driven to 0, so the outputs are always fully determined.

Top module: `insn_ctl_decoder`

## Requirements
- R1: Opcode 000000 with a supported function code gives dst_is_rd_o=1, reg_wr_o=1, src_is_imm_o=0 and sext_imm_o=0. It also gives mem_rd_o, mem_wr_o, wb_from_mem_o, br_eq_o, br_ne_o and jump_o all 0.
- R2: Under opcode 000000 the ALU code depends on the function code: 100000 (add) gives 0010, 100010 (sub) gives 0110, 100100 (and) gives 0000, 100101 (or) gives 0001, and 101010 (slt) gives 0111.
- R3: addi (opcode 001000) gives reg_wr_o=1, src_is_imm_o=1, sext_imm_o=1, dst_is_rd_o=0 and ALU code 0010. Every other output is 0.
- R4: andi (001100) and ori (001101) each give reg_wr_o=1, src_is_imm_o=1, sext_imm_o=0 (zero extend) and dst_is_rd_o=0. The ALU code is 0000 for andi and 0001 for ori. Every other output is 0.
- R5: lw (100011) gives reg_wr_o=1, sext_imm_o=1, src_is_imm_o=1, mem_rd_o=1, wb_from_mem_o=1, mem_wr_o=0, dst_is_rd_o=0 and ALU code 0010. The branch and jump flags are 0.
- R6: sw (101011) gives mem_wr_o=1, sext_imm_o=1, src_is_imm_o=1 and ALU code 0010. Every other output is 0.
- R7: beq (000100) gives br_eq_o=1 and ALU code 0110; bne (000101) gives br_ne_o=1 and ALU code 0110. Every other output is 0 for both.
- R8: j (000010) gives jump_o=1 with every other output 0, including ALU code 0000.
- R9: An opcode outside the supported set drives every output to 0.
- R10: Opcode 000000 with an unsupported function code drives every output to 0.
- R11: When the opcode is not 000000, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction bits 31:26 |
| funct_i | input | 6 | Instruction bits 5:0 |
| dst_is_rd_o | output | 1 | 1: write to rd field, 0: rt field |
| reg_wr_o | output | 1 | Register file write enable |
| sext_imm_o | output | 1 | 1: sign extend the 16-bit immediate, 0: zero extend |
| src_is_imm_o | output | 1 | 1: ALU second operand is the extended immediate |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| wb_from_mem_o | output | 1 | 1: write-back data comes from memory |
| br_eq_o | output | 1 | Branch when ALU result is zero |
| br_ne_o | output | 1 | Branch when ALU result is non-zero |
| jump_o | output | 1 | Unconditional jump |
| alu_op_o | output | 4 | ALU operation code |

## Verification
Every supported opcode is applied with two different function fields. This tells a decode that truly ignores the function field apart from one that only happens to match for a single value. Under opcode 000000, each of the five function codes is applied, so a swapped entry in the ALU table shows up.

Near-miss opcodes and function codes are also applied, each one bit away from a legal value, together with the all-zero and all-one patterns. These separate exact matching from partial matching and confirm that unknown encodings leave every control inert. A final sweep over all 64 opcodes confirms that only the listed ones produce any active output.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 4;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE   = 6'b000101;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'b001100;
  localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef enum logic [ALU_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_op_e;

  typedef struct packed {
    logic dst_is_rd;
    logic reg_wr;
    logic sext_imm;
    logic src_is_imm;
    logic mem_rd;
    logic mem_wr;
    logic wb_from_mem;
    logic br_eq;
    logic br_ne;
    logic jump;
  } ctl_t;

  localparam ctl_t CTL_INERT = '0;

  // Returns {legal, code} for a register-register function field.
  function automatic logic [ALU_W:0] funct_to_alu(input logic [FN_W-1:0] fn);
    case (fn)
      FN_ADD:  return {1'b1, ALU_ADD};
      FN_SUB:  return {1'b1, ALU_SUB};
      FN_AND:  return {1'b1, ALU_AND};
      FN_OR:   return {1'b1, ALU_OR};
      FN_SLT:  return {1'b1, ALU_SLT};
      default: return {1'b0, ALU_AND};
    endcase
  endfunction
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output ctl_t            ctl_o,
  output logic            is_rtype_o,
  output logic            op_known_o
);
  ctl_t c;

  always_comb begin
    c          = CTL_INERT;
    op_known_o = 1'b1;
    case (opcode_i)
      OP_RTYPE: begin c.dst_is_rd = 1'b1; c.reg_wr = 1'b1; end
      OP_ADDI:  begin c.reg_wr = 1'b1; c.src_is_imm = 1'b1; c.sext_imm = 1'b1; end
      OP_ANDI,
      OP_ORI:   begin c.reg_wr = 1'b1; c.src_is_imm = 1'b1; end
      OP_LW:    begin
        c.reg_wr = 1'b1; c.src_is_imm = 1'b1; c.sext_imm = 1'b1;
        c.mem_rd = 1'b1; c.wb_from_mem = 1'b1;
      end
      OP_SW:    begin c.mem_wr = 1'b1; c.src_is_imm = 1'b1; c.sext_imm = 1'b1; end
      OP_BEQ:   c.br_eq = 1'b1;
      OP_BNE:   c.br_ne = 1'b1;
      OP_JMP:   c.jump  = 1'b1;
      default:  op_known_o = 1'b0;
    endcase
  end

  assign ctl_o      = c;
  assign is_rtype_o = (opcode_i == OP_RTYPE);

  always_comb begin
    p_unknown_inert_r9: assert (op_known_o || (ctl_o == CTL_INERT))
      else $error("unknown opcode drives an active control");
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             funct_ok_o
);
  logic [ALU_W:0] fn_dec;

  assign fn_dec = funct_to_alu(funct_i);

  always_comb begin
    funct_ok_o = 1'b0;
    case (opcode_i)
      OP_RTYPE: begin alu_op_o = fn_dec[ALU_W-1:0]; funct_ok_o = fn_dec[ALU_W]; end
      OP_ADDI, OP_LW, OP_SW: alu_op_o = ALU_ADD;
      OP_ANDI:               alu_op_o = ALU_AND;
      OP_ORI:                alu_op_o = ALU_OR;
      OP_BEQ, OP_BNE:        alu_op_o = ALU_SUB;
      default:               alu_op_o = ALU_AND;
    endcase
  end

  always_comb begin
    p_rtype_no_nor_r2: assert (!(opcode_i == OP_RTYPE) || (alu_op_o != ALU_NOR))
      else $error("register-register decode produced NOR");
  end
endmodule

// File: rtl/insn_ctl_decoder.sv
module insn_ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output logic       dst_is_rd_o,
  output logic       reg_wr_o,
  output logic       sext_imm_o,
  output logic       src_is_imm_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       wb_from_mem_o,
  output logic       br_eq_o,
  output logic       br_ne_o,
  output logic       jump_o,
  output logic [3:0] alu_op_o
);
  ctl_t             main_ctl;
  ctl_t             final_ctl;
  logic             is_rtype;
  logic             op_known;
  logic             funct_ok;
  logic             rtype_bad;
  logic [ALU_W-1:0] alu_raw;
  logic             flow_any;

  ctl_main_dec u_main (
    .opcode_i   (opcode_i),
    .ctl_o      (main_ctl),
    .is_rtype_o (is_rtype),
    .op_known_o (op_known)
  );

  ctl_alu_dec u_alu (
    .opcode_i   (opcode_i),
    .funct_i    (funct_i),
    .alu_op_o   (alu_raw),
    .funct_ok_o (funct_ok)
  );

  // R10: an unsupported function under opcode 000000 makes the whole word inert.
  assign rtype_bad = is_rtype && !funct_ok;
  assign final_ctl = rtype_bad ? CTL_INERT : main_ctl;

  assign dst_is_rd_o   = final_ctl.dst_is_rd;
  assign reg_wr_o      = final_ctl.reg_wr;
  assign sext_imm_o    = final_ctl.sext_imm;
  assign src_is_imm_o  = final_ctl.src_is_imm;
  assign mem_rd_o      = final_ctl.mem_rd;
  assign mem_wr_o      = final_ctl.mem_wr;
  assign wb_from_mem_o = final_ctl.wb_from_mem;
  assign br_eq_o       = final_ctl.br_eq;
  assign br_ne_o       = final_ctl.br_ne;
  assign jump_o        = final_ctl.jump;
  assign alu_op_o      = rtype_bad ? ALU_AND : alu_raw;

  assign flow_any = br_eq_o || br_ne_o || jump_o;

  always_comb begin
    p_flow_onehot_r7: assert ($onehot0({br_eq_o, br_ne_o, jump_o}))
      else $error("more than one next-PC flag");
    p_flow_no_write_r8: assert (!flow_any || !(reg_wr_o || mem_rd_o || mem_wr_o))
      else $error("control-flow word writes state");
    p_branch_sub_r7: assert (!(br_eq_o || br_ne_o) || (alu_op_o == ALU_SUB))
      else $error("branch without subtract");
    p_mem_excl_r6: assert (!(mem_rd_o && mem_wr_o))
      else $error("memory read and write together");
    p_wb_mem_r5: assert (wb_from_mem_o == mem_rd_o)
      else $error("write-back source disagrees with memory read");
    p_bad_funct_r10: assert (!rtype_bad || !(reg_wr_o || dst_is_rd_o))
      else $error("bad function code still writes");
  end
endmodule

// File: tb/test_insn_ctl_decoder.sv
module test_insn_ctl_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0] opcode, funct;
  logic dst_is_rd, reg_wr, sext_imm, src_is_imm, mem_rd, mem_wr, wb_mem, br_eq, br_ne, jump;
  logic [3:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  insn_ctl_decoder i_insn_ctl_decoder (
    .opcode_i(opcode), .funct_i(funct),
    .dst_is_rd_o(dst_is_rd), .reg_wr_o(reg_wr), .sext_imm_o(sext_imm),
    .src_is_imm_o(src_is_imm), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .wb_from_mem_o(wb_mem), .br_eq_o(br_eq), .br_ne_o(br_ne), .jump_o(jump),
    .alu_op_o(alu_op)
  );

  // Expected vector: {dst,wr,sext,imm,mrd,mwr,wbm,beq,bne,j,alu[3:0]}
  function automatic logic [13:0] observed();
    return {dst_is_rd, reg_wr, sext_imm, src_is_imm, mem_rd, mem_wr, wb_mem,
            br_eq, br_ne, jump, alu_op};
  endfunction

  task automatic apply_check(input string req, input logic [5:0] op,
                             input logic [5:0] fn, input logic [13:0] exp);
    @(negedge clk);
    opcode = op; funct = fn;
    #1;
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, op, fn, observed(), exp);
    end
  endtask

  localparam logic [13:0] INERT = 14'b0;

  task automatic t_idle_r10();
    apply_check("R10 zero word", 6'b000000, 6'b000000, INERT);
  endtask

  task automatic t_rtype_r1_r2();
    apply_check("R1 R2 add", 6'b000000, 6'b100000, {10'b1100000000, 4'b0010});
    apply_check("R1 R2 sub", 6'b000000, 6'b100010, {10'b1100000000, 4'b0110});
    apply_check("R1 R2 and", 6'b000000, 6'b100100, {10'b1100000000, 4'b0000});
    apply_check("R1 R2 or",  6'b000000, 6'b100101, {10'b1100000000, 4'b0001});
    apply_check("R1 R2 slt", 6'b000000, 6'b101010, {10'b1100000000, 4'b0111});
  endtask

  task automatic t_rtype_bad_r10();
    apply_check("R10 fn 100001", 6'b000000, 6'b100001, INERT);
    apply_check("R10 fn 101011", 6'b000000, 6'b101011, INERT);
    apply_check("R10 fn 111111", 6'b000000, 6'b111111, INERT);
  endtask

  task automatic t_imm_alu_r3_r4_r11();
    apply_check("R3 addi",     6'b001000, 6'b000000, {10'b0111000000, 4'b0010});
    apply_check("R3 R11 addi", 6'b001000, 6'b100010, {10'b0111000000, 4'b0010});
    apply_check("R4 andi",     6'b001100, 6'b000000, {10'b0101000000, 4'b0000});
    apply_check("R4 R11 andi", 6'b001100, 6'b100101, {10'b0101000000, 4'b0000});
    apply_check("R4 ori",      6'b001101, 6'b000000, {10'b0101000000, 4'b0001});
    apply_check("R4 R11 ori",  6'b001101, 6'b101010, {10'b0101000000, 4'b0001});
  endtask

  task automatic t_mem_r5_r6_r11();
    apply_check("R5 lw",     6'b100011, 6'b000000, {10'b0111101000, 4'b0010});
    apply_check("R5 R11 lw", 6'b100011, 6'b100100, {10'b0111101000, 4'b0010});
    apply_check("R6 sw",     6'b101011, 6'b000000, {10'b0011010000, 4'b0010});
    apply_check("R6 R11 sw", 6'b101011, 6'b111111, {10'b0011010000, 4'b0010});
  endtask

  task automatic t_flow_r7_r8_r11();
    apply_check("R7 beq",     6'b000100, 6'b000000, {10'b0000000100, 4'b0110});
    apply_check("R7 R11 beq", 6'b000100, 6'b100000, {10'b0000000100, 4'b0110});
    apply_check("R7 bne",     6'b000101, 6'b000000, {10'b0000000010, 4'b0110});
    apply_check("R7 R11 bne", 6'b000101, 6'b101010, {10'b0000000010, 4'b0110});
    apply_check("R8 j",       6'b000010, 6'b000000, {10'b0000000001, 4'b0000});
    apply_check("R8 R11 j",   6'b000010, 6'b100010, {10'b0000000001, 4'b0000});
  endtask

  task automatic t_unknown_r9();
    apply_check("R9 op 000011", 6'b000011, 6'b100000, INERT);
    apply_check("R9 op 100011^1", 6'b100010, 6'b000000, INERT);
    apply_check("R9 op 101010", 6'b101010, 6'b100000, INERT);
    apply_check("R9 op 111111", 6'b111111, 6'b111111, INERT);
    // Sweep: every opcode outside the supported list is inert.
    for (int k = 0; k < 64; k++) begin
      logic [5:0] o;
      o = 6'(k);
      if (!(o inside {6'b000000, 6'b000010, 6'b000100, 6'b000101, 6'b001000,
                      6'b001100, 6'b001101, 6'b100011, 6'b101011}))
        apply_check("R9 sweep", o, 6'b100000, INERT);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    opcode = '0; funct = '0;
    repeat (2) @(posedge clk);
    t_idle_r10();
    t_rtype_r1_r2();
    t_rtype_bad_r10();
    t_imm_alu_r3_r4_r11();
    t_mem_r5_r6_r11();
    t_flow_r7_r8_r11();
    t_unknown_r9();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule